// File: doc/BRIEF.md
# Tag Propagation Rule Cache

This block sits beside the dispatch stage of a processor in which every register and memory word carries a full-width tag. At each dispatch the pipeline presents an argument tuple to the cache. The tuple holds the opcode, the current program-counter tag and three operand tags, and the requester writes zero into any operand slot the opcode does not use. The cache searches its rule instances by fully associative compare. On a hit it returns the tag the program counter takes after the instruction and the tag for any word the instruction produces. The pipeline merges these tags with the ordinary result, which is computed in parallel, so a hit adds no serial delay to the data path.

When no rule matches, the pipeline must not commit the instruction, and the cache raises a fault request that carries the tuple toward trusted handler software. The handler takes one of two actions. It can drop the request with the abort input when it decides the tuple violates policy. It can instead write a rule instance through the install port, after which the pipeline replays the faulting instruction from the start. A one-cycle flush input empties the cache.

Back-pressure on the request stream: `req_ready` is low in any cycle where `inst_valid` is high, and a request is taken only on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields while `req_ready` is low. Back-pressure on the install stream: `inst_ready` is low while `flush` is high, and an install offered in that cycle is dropped. The response carries no ready signal, because dispatch consumes it in the cycle it appears.

Top module: `tag_rule_cache`

## Requirements
- R1: A request accepted at a clock edge produces `rsp_valid`=1 in the cycle that follows. On a hit, `rsp_pc_tag` and `rsp_res_tag` equal the two tags most recently installed for that exact tuple.
- R2: A response with `rsp_hit`=0 raises `fault_valid` at the next edge. The fault fields then carry the missing tuple, packed as {opcode, pc tag, tag a, tag b, tag c}.
- R3: Once raised, `fault_valid` and its tuple hold steady, and later misses do not change them. The fault clears at the edge after either a hit response for that same tuple or an `abort` pulse.
- R4: After a rule is installed for a tuple, replaying that tuple hits.
- R5: Installing a tuple that is already present overwrites that entry in place. No duplicate is created and no other entry is displaced.
- R6: Installing a new tuple while some entry is empty fills the lowest-numbered empty entry.
- R7: Installing a new tuple while all 8 entries are valid replaces the entry at a round-robin pointer. The pointer starts at entry 0 after reset, advances by one on each such replacement and wraps from 7 to 0. It is not reset by flush.
- R8: A `flush` pulse invalidates every entry, so every later lookup misses until new installs arrive.
- R9: `req_ready` is low while `inst_valid` is high. `inst_ready` is low while `flush` is high, and an install offered in that cycle has no effect.
- R10: After reset, `rsp_valid`=0, `fault_valid`=0, `req_ready`=1, `inst_ready`=1, and the cache holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup tuple offered |
| req_ready | output | 1 | Lookup tuple can be taken |
| req_opcode | input | 5 | Opcode of the dispatched instruction |
| req_pc_tag | input | 16 | Current program-counter tag |
| req_tag_a | input | 16 | First operand tag (zero if unused) |
| req_tag_b | input | 16 | Second operand tag (zero if unused) |
| req_tag_c | input | 16 | Third operand tag (zero if unused) |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Tuple is allowed by a cached rule |
| rsp_pc_tag | output | 16 | Program-counter tag after the instruction (zero on a miss) |
| rsp_res_tag | output | 16 | Tag for the produced word (zero on a miss) |
| fault_valid | output | 1 | Fault request pending toward the handler |
| fault_opcode | output | 5 | Faulting opcode |
| fault_pc_tag | output | 16 | Faulting program-counter tag |
| fault_tag_a | output | 16 | Faulting first operand tag |
| fault_tag_b | output | 16 | Faulting second operand tag |
| fault_tag_c | output | 16 | Faulting third operand tag |
| abort | input | 1 | Handler drops the pending fault |
| inst_valid | input | 1 | Rule instance offered for install |
| inst_ready | output | 1 | Install can be taken |
| inst_opcode | input | 5 | Key opcode of the rule |
| inst_pc_tag | input | 16 | Key program-counter tag of the rule |
| inst_tag_a | input | 16 | Key first operand tag |
| inst_tag_b | input | 16 | Key second operand tag |
| inst_tag_c | input | 16 | Key third operand tag |
| inst_new_pc_tag | input | 16 | Program-counter tag the rule yields |
| inst_res_tag | input | 16 | Result tag the rule yields |
| flush | input | 1 | Invalidate all entries |

## Verification
A request driven before edge N has its response checked in the cycle after N, away from the next edge. The fault request is checked one cycle later still, because it passes through one more register after the missed response. The clearing of a fault by `abort` or by a replay hit is sampled in the cycle after the edge that carries that event. An install or flush takes effect at its edge, so the bench reads its result only through a later lookup. Expected hits and tags come from a bench-side table of 8 slots that follows the fill and round-robin rules, and a sweep of 20 tuples is compared against that table after each phase.

// File: rtl/tag_rule_pkg.sv
package tag_rule_pkg;
  localparam int TRC_TAG_W   = 16;
  localparam int TRC_OP_W    = 5;
  localparam int TRC_ENTRIES = 8;
  localparam int TRC_OPERANDS = 3;

  typedef enum logic {
    MS_IDLE  = 1'b0,
    MS_FAULT = 1'b1
  } miss_state_e;
endpackage

// File: rtl/trc_rule_store.sv
module trc_rule_store #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 69,
  parameter int RES_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_key,
  input  logic [RES_W-1:0]   wr_res,
  input  logic [KEY_W-1:0]   lk_key,
  output logic [ENTRIES-1:0] lk_match,
  output logic [RES_W-1:0]   lk_res,
  output logic [ENTRIES-1:0] wr_match,
  output logic [ENTRIES-1:0] valid
);
  logic [KEY_W-1:0] key_q [ENTRIES];
  logic [RES_W-1:0] res_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid[g] <= 1'b0;
        key_q[g] <= '0;
        res_q[g] <= '0;
      end else if (flush) begin
        valid[g] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid[g] <= 1'b1;
        key_q[g] <= wr_key;
        res_q[g] <= wr_res;
      end
    end
    assign lk_match[g] = valid[g] && (key_q[g] == lk_key);
    assign wr_match[g] = valid[g] && (key_q[g] == wr_key);
  end

  always_comb begin
    lk_res = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_res = lk_res | res_q[i];
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0)); // R8
endmodule

// File: rtl/trc_victim_sel.sv
module trc_victim_sel #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               install,
  input  logic [ENTRIES-1:0] wr_match,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   wr_idx
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] match_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_match;
  logic             any_free;
  logic             evict;

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (wr_match[i]) match_idx = IDX_W'(i);
      if (!valid[i])   free_idx  = IDX_W'(i);
    end
  end

  assign any_match = |wr_match;
  assign any_free  = ~&valid;
  assign evict     = install && !any_match && !any_free;
  assign wr_idx    = any_match ? match_idx : (any_free ? free_idx : ptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (evict) begin
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  AST_FILL_EMPTY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (install && !any_match && any_free) |-> !valid[wr_idx]); // R6
  AST_PTR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (install && !any_match && !any_free) |=>
      (ptr_q == (($past(ptr_q) == IDX_W'(ENTRIES - 1)) ? '0 : $past(ptr_q) + 1'b1))); // R7
  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !evict |=> $stable(ptr_q)); // R7
endmodule

// File: rtl/trc_miss_ctrl.sv
module trc_miss_ctrl import tag_rule_pkg::*; #(
  parameter int KEY_W = 69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             look_valid,
  input  logic             look_hit,
  input  logic [KEY_W-1:0] look_key,
  input  logic             abort,
  output logic             fault_valid,
  output logic [KEY_W-1:0] fault_key
);
  miss_state_e state_q;
  logic        replay_hit;

  assign replay_hit  = look_valid && look_hit && (look_key == fault_key);
  assign fault_valid = (state_q == MS_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= MS_IDLE;
      fault_key <= '0;
    end else begin
      case (state_q)
        MS_IDLE: begin
          if (look_valid && !look_hit && !abort) begin
            state_q   <= MS_FAULT;
            fault_key <= look_key;
          end
        end
        MS_FAULT: begin
          if (abort || replay_hit) state_q <= MS_IDLE;
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !abort && !(look_valid && look_hit)) |=>
      (fault_valid && $stable(fault_key))); // R3
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !fault_valid); // R3
endmodule

// File: rtl/tag_rule_cache.sv
module tag_rule_cache import tag_rule_pkg::*; #(
  parameter int TAG_W   = TRC_TAG_W,
  parameter int OP_W    = TRC_OP_W,
  parameter int ENTRIES = TRC_ENTRIES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OP_W-1:0]  req_opcode,
  input  logic [TAG_W-1:0] req_pc_tag,
  input  logic [TAG_W-1:0] req_tag_a,
  input  logic [TAG_W-1:0] req_tag_b,
  input  logic [TAG_W-1:0] req_tag_c,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [TAG_W-1:0] rsp_pc_tag,
  output logic [TAG_W-1:0] rsp_res_tag,
  output logic             fault_valid,
  output logic [OP_W-1:0]  fault_opcode,
  output logic [TAG_W-1:0] fault_pc_tag,
  output logic [TAG_W-1:0] fault_tag_a,
  output logic [TAG_W-1:0] fault_tag_b,
  output logic [TAG_W-1:0] fault_tag_c,
  input  logic             abort,
  input  logic             inst_valid,
  output logic             inst_ready,
  input  logic [OP_W-1:0]  inst_opcode,
  input  logic [TAG_W-1:0] inst_pc_tag,
  input  logic [TAG_W-1:0] inst_tag_a,
  input  logic [TAG_W-1:0] inst_tag_b,
  input  logic [TAG_W-1:0] inst_tag_c,
  input  logic [TAG_W-1:0] inst_new_pc_tag,
  input  logic [TAG_W-1:0] inst_res_tag,
  input  logic             flush
);
  localparam int KEY_W = OP_W + (TRC_OPERANDS + 1) * TAG_W;
  localparam int RES_W = 2 * TAG_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic               q_valid;
  logic [KEY_W-1:0]   q_key;
  logic               accept;
  logic               install;
  logic [KEY_W-1:0]   inst_key;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] wr_match;
  logic [ENTRIES-1:0] valid;
  logic [RES_W-1:0]   lk_res;
  logic [IDX_W-1:0]   wr_idx;
  logic [KEY_W-1:0]   fault_key;

  assign req_ready  = !inst_valid;
  assign inst_ready = !flush;
  assign accept     = req_valid && req_ready;
  assign install    = inst_valid && inst_ready;
  assign inst_key   = {inst_opcode, inst_pc_tag, inst_tag_a, inst_tag_b, inst_tag_c};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_key   <= '0;
    end else begin
      q_valid <= accept;
      if (accept) q_key <= {req_opcode, req_pc_tag, req_tag_a, req_tag_b, req_tag_c};
    end
  end

  trc_rule_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .RES_W(RES_W)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (install),
    .wr_idx   (wr_idx),
    .wr_key   (inst_key),
    .wr_res   ({inst_new_pc_tag, inst_res_tag}),
    .lk_key   (q_key),
    .lk_match (lk_match),
    .lk_res   (lk_res),
    .wr_match (wr_match),
    .valid    (valid)
  );

  trc_victim_sel #(.ENTRIES(ENTRIES)) i_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .install  (install),
    .wr_match (wr_match),
    .valid    (valid),
    .wr_idx   (wr_idx)
  );

  trc_miss_ctrl #(.KEY_W(KEY_W)) i_miss (
    .clk         (clk),
    .rst_n       (rst_n),
    .look_valid  (q_valid),
    .look_hit    (|lk_match),
    .look_key    (q_key),
    .abort       (abort),
    .fault_valid (fault_valid),
    .fault_key   (fault_key)
  );

  assign rsp_valid = q_valid;
  assign rsp_hit   = q_valid && (|lk_match);
  assign {rsp_pc_tag, rsp_res_tag} = rsp_hit ? lk_res : '0;
  assign {fault_opcode, fault_pc_tag, fault_tag_a, fault_tag_b, fault_tag_c} = fault_key;

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R1
  AST_MISS_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && !abort && !fault_valid) |=>
      (fault_valid && fault_key == $past(q_key))); // R2
  AST_STALL_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !rsp_valid); // R9
endmodule

// File: tb/test_tag_rule_cache.sv
module test_tag_rule_cache;
  localparam int TAG_W = 16;
  localparam int OP_W  = 5;
  localparam int N     = 8;
  localparam int KEY_W = OP_W + 4 * TAG_W;
  localparam int NKEYS = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [KEY_W-1:0] req_key = '0;
  logic             rsp_valid, rsp_hit;
  logic [TAG_W-1:0] rsp_pc_tag, rsp_res_tag;
  logic             fault_valid;
  logic [OP_W-1:0]  fault_opcode;
  logic [TAG_W-1:0] fault_pc_tag, fault_tag_a, fault_tag_b, fault_tag_c;
  logic             abort = 1'b0;
  logic             inst_valid = 1'b0;
  logic             inst_ready;
  logic [KEY_W-1:0] inst_key = '0;
  logic [TAG_W-1:0] inst_new_pc_tag = '0, inst_res_tag = '0;
  logic             flush = 1'b0;

  tag_rule_cache i_tag_rule_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_key[KEY_W-1 -: OP_W]), .req_pc_tag(req_key[4*TAG_W-1 -: TAG_W]),
    .req_tag_a(req_key[3*TAG_W-1 -: TAG_W]), .req_tag_b(req_key[2*TAG_W-1 -: TAG_W]),
    .req_tag_c(req_key[TAG_W-1:0]),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pc_tag(rsp_pc_tag), .rsp_res_tag(rsp_res_tag),
    .fault_valid(fault_valid), .fault_opcode(fault_opcode), .fault_pc_tag(fault_pc_tag),
    .fault_tag_a(fault_tag_a), .fault_tag_b(fault_tag_b), .fault_tag_c(fault_tag_c),
    .abort(abort), .inst_valid(inst_valid), .inst_ready(inst_ready),
    .inst_opcode(inst_key[KEY_W-1 -: OP_W]), .inst_pc_tag(inst_key[4*TAG_W-1 -: TAG_W]),
    .inst_tag_a(inst_key[3*TAG_W-1 -: TAG_W]), .inst_tag_b(inst_key[2*TAG_W-1 -: TAG_W]),
    .inst_tag_c(inst_key[TAG_W-1:0]),
    .inst_new_pc_tag(inst_new_pc_tag), .inst_res_tag(inst_res_tag), .flush(flush)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Reference table: slot contents, fill and round-robin rules from R5..R8
  logic             m_valid [N];
  logic [KEY_W-1:0] m_key   [N];
  logic [2*TAG_W-1:0] m_res [N];
  int               m_ptr = 0;

  function automatic logic [KEY_W-1:0] mk_key(int i);
    return {OP_W'(i * 3 + 1), TAG_W'(i * 4099 + 17), TAG_W'(i * 7 + 3),
            TAG_W'(i ^ 'h5a), TAG_W'((i % 3 == 0) ? 0 : i * 13)};
  endfunction

  function automatic logic [2*TAG_W-1:0] mk_res(int i, int v);
    return {TAG_W'(i * 257 + v), TAG_W'(16'hc000 + i * 11 + v * 5)};
  endfunction

  function automatic int m_find(logic [KEY_W-1:0] k);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_key[i] == k) return i;
    return -1;
  endfunction

  function automatic void m_install(logic [KEY_W-1:0] k, logic [2*TAG_W-1:0] r);
    int slot = m_find(k);
    if (slot < 0) begin
      for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
    end
    if (slot < 0) begin
      slot  = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_valid[slot] = 1'b1;
    m_key[slot]   = k;
    m_res[slot]   = r;
  endfunction

  task automatic check(bit ok, string req, logic [KEY_W-1:0] act, logic [KEY_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_lookup(logic [KEY_W-1:0] k);
    @(negedge clk);
    req_key   = k;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Lookup compared with the table; a miss is checked for its fault and then aborted
  task automatic check_lookup(logic [KEY_W-1:0] k, string req);
    int slot = m_find(k);
    do_lookup(k);
    check(rsp_valid == 1'b1, "R1 rsp_valid", KEY_W'(rsp_valid), 1);
    check(rsp_hit == (slot >= 0), req, KEY_W'(rsp_hit), KEY_W'(slot >= 0));
    if (slot >= 0) begin
      check({rsp_pc_tag, rsp_res_tag} == m_res[slot], "R1 tags",
            KEY_W'({rsp_pc_tag, rsp_res_tag}), KEY_W'(m_res[slot]));
    end else begin
      @(negedge clk);
      check(fault_valid && {fault_opcode, fault_pc_tag, fault_tag_a, fault_tag_b, fault_tag_c} == k,
            "R2 fault tuple",
            {fault_opcode, fault_pc_tag, fault_tag_a, fault_tag_b, fault_tag_c}, k);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      check(!fault_valid, "R3 abort clears", KEY_W'(fault_valid), 0);
    end
  endtask

  task automatic do_install(logic [KEY_W-1:0] k, logic [2*TAG_W-1:0] r);
    @(negedge clk);
    inst_key = k;
    {inst_new_pc_tag, inst_res_tag} = r;
    inst_valid = 1'b1;
    #1;
    check(req_ready == 1'b0, "R9 req_ready low during install", KEY_W'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    inst_valid = 1'b0;
    m_install(k, r);
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < NKEYS; i++) check_lookup(mk_key(i), req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0;
      m_key[i]   = '0;
      m_res[i]   = '0;
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(rsp_valid == 1'b0, "R10 rsp_valid", KEY_W'(rsp_valid), 0);
    check(fault_valid == 1'b0, "R10 fault_valid", KEY_W'(fault_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && inst_ready, "R10 ready", KEY_W'({req_ready, inst_ready}), 3);
    sweep("R10 empty after reset");

    // R2/R3/R4 miss, hold, install, replay
    do_lookup(mk_key(0));
    check(!rsp_hit, "R2 first miss", KEY_W'(rsp_hit), 0);
    repeat (3) @(negedge clk);
    check(fault_valid && {fault_opcode, fault_pc_tag, fault_tag_a, fault_tag_b, fault_tag_c} == mk_key(0),
          "R3 fault held", {fault_opcode, fault_pc_tag, fault_tag_a, fault_tag_b, fault_tag_c}, mk_key(0));
    do_lookup(mk_key(5));
    @(negedge clk);
    check({fault_opcode, fault_pc_tag, fault_tag_a, fault_tag_b, fault_tag_c} == mk_key(0),
          "R3 later miss ignored", {fault_opcode, fault_pc_tag, fault_tag_a, fault_tag_b, fault_tag_c}, mk_key(0));
    do_install(mk_key(0), mk_res(0, 1));
    check(fault_valid, "R3 install alone keeps fault", KEY_W'(fault_valid), 1);
    do_lookup(mk_key(0));
    check(rsp_hit && {rsp_pc_tag, rsp_res_tag} == mk_res(0, 1), "R4 replay hits",
          KEY_W'({rsp_hit, rsp_pc_tag, rsp_res_tag}), KEY_W'({1'b1, mk_res(0, 1)}));
    @(negedge clk);
    check(!fault_valid, "R3 replay hit clears", KEY_W'(fault_valid), 0);

    // R6 fill, R5 overwrite in place
    for (int i = 1; i < N; i++) do_install(mk_key(i), mk_res(i, 0));
    sweep("R6 fill");
    do_install(mk_key(3), mk_res(3, 9));
    sweep("R5 overwrite");

    // R7 round-robin eviction, with wrap
    for (int i = N; i < 2 * N + 3; i++) begin
      do_install(mk_key(i % NKEYS), mk_res(i, 2));
      check_lookup(mk_key(i % NKEYS), "R7 new entry hits");
    end
    sweep("R7 eviction order");

    // R8 flush and R9 install dropped during flush
    @(negedge clk);
    flush = 1'b1;
    inst_key = mk_key(19);
    {inst_new_pc_tag, inst_res_tag} = mk_res(19, 7);
    inst_valid = 1'b1;
    #1;
    check(inst_ready == 1'b0, "R9 inst_ready low in flush", KEY_W'(inst_ready), 0);
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
    inst_valid = 1'b0;
    for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    sweep("R8 flush empties");

    // R6 lowest empty slot after flush, then R7 pointer carried over
    for (int i = 0; i < N + 4; i++) do_install(mk_key(NKEYS - 1 - i), mk_res(i, 4));
    sweep("R6 R7 refill after flush");
    for (int i = 0; i < 5; i++) do_install(mk_key(i), mk_res(i, 5 + i));
    sweep("R7 final");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule